// File: doc/BRIEF.md
# Message-Signalled Interrupt Generator

This block sits next to a peripheral and turns each local event pulse into one write on the system bus. The write is made to an address that software programs at run time. A master subscribes to the peripheral's interrupts by storing its own receiving address in the block's target register. From then on, every event produces a separate write of a programmable data word to that address. The receiver finishes each message by returning the ordinary bus acknowledge. If the receiver stalls, the write simply waits, so no mask or enable logic is needed.

The block has two bus ports. The configuration port is a pipelined slave with a small register window. The message port is a pipelined master that issues single writes. A saturating pending counter records events that arrive while an earlier message is still in flight, or while no destination has been programmed. Each recorded event is later sent as its own message.

Top module: `irq_msg_sender`

## Requirements
- R1: After reset, the pending count and both configuration registers are zero, and `mCyc` and `mStb` are low.
- R2: Configuration word index 0 is the target address and index 1 is the message data word. Indices 2 and 3 read as zero and ignore writes. Every configuration access is acknowledged with `cfgAck` high in the cycle after `cfgCyc`/`cfgStb` are sampled. Read data appears on `cfgDatR` in that same acknowledge cycle.
- R3: Each accepted event pulse produces exactly one write with `mWe` high, `mAdr` equal to the target register and `mDat` equal to the data register. N pulses give N writes.
- R4: While `mStb` is high and `mStall` is high, `mStb` stays high and `mAdr`/`mDat` stay unchanged.
- R5: In the cycle after a strobe is taken (`mStall` low), `mStb` is low and `mCyc` stays high. `mCyc` stays high until `mAck`, and it is low in the cycle after `mAck`, so a new message starts only after the previous one is acknowledged.
- R6: While the target register is zero, events are counted but no write is issued. Writing a non-zero target then sends all counted events.
- R7: The pending count saturates at 2^CNT_W-1 (255 with the default CNT_W=8). Events beyond that are dropped.
- R8: An event pulse in the same cycle as a message acknowledge leaves the pending count unchanged, so that event is still delivered.
- R9: A write to the data register while a message is in flight does not alter that message. The new value is used from the next message onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| eventPulse | input | 1 | One-cycle event request from the peripheral |
| cfgCyc | input | 1 | Configuration slave cycle |
| cfgStb | input | 1 | Configuration slave strobe |
| cfgWe | input | 1 | Configuration write enable |
| cfgAdr | input | CFG_AW | Configuration word index |
| cfgDatW | input | BUS_W | Configuration write data |
| cfgAck | output | 1 | Configuration acknowledge |
| cfgDatR | output | BUS_W | Configuration read data |
| mCyc | output | 1 | Message master cycle |
| mStb | output | 1 | Message master strobe |
| mWe | output | 1 | Message master write enable |
| mAdr | output | BUS_W | Message destination address |
| mDat | output | BUS_W | Message data word |
| mStall | input | 1 | Receiver stall |
| mAck | input | 1 | Receiver acknowledge |

## Verification
On every cycle, the assertions cover the handshake on the message port:
- strobe and payload held still while stalled (R4);
- strobe dropped after acceptance, cycle held until the acknowledge and released afterwards (R5);
- no strobe toward a zero address (R6);
- the one-cycle configuration acknowledge (R2).

Other properties depend on counting and history across many messages, so only the bench scenarios can show them:
- one message per event (R3);
- saturation of the pending count (R7);
- no loss when an event coincides with an acknowledge (R8);
- a data update taking effect only on the following message (R9).

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

  // Sequencing phases of the message master.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } msgState_t;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic latchMsg;  // capture target and data for a new message
    logic msgDone;   // current message acknowledged by the receiver
  } ctlStrobe_t;

  // Configuration window layout.
  localparam int unsigned NUM_CFG_REGS = 2;
  localparam int unsigned REG_TARGET   = 0;
  localparam int unsigned REG_DATA     = 1;

endpackage

// File: rtl/irq_msg_datapath.sv
module irq_msg_datapath
  import irq_msg_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int CNT_W  = 8,
  parameter int CFG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eventPulse,
  input  logic              cfgCyc,
  input  logic              cfgStb,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAdr,
  input  logic [BUS_W-1:0]  cfgDatW,
  output logic              cfgAck,
  output logic [BUS_W-1:0]  cfgDatR,
  input  ctlStrobe_t        strobe,
  output logic [BUS_W-1:0]  msgAdr,
  output logic [BUS_W-1:0]  msgDat,
  output logic              pendingAny,
  output logic              targetValid
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ZERO = {CNT_W{1'b0}};
  localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic                 cfgAccess;
  logic                 cfgWrite;
  logic [BUS_W-1:0]     cfgRegs [NUM_CFG_REGS];
  logic [BUS_W-1:0]     readVal;
  logic [CNT_W-1:0]     pendCnt;
  logic [CNT_W-1:0]     pendNext;

  assign cfgAccess = cfgCyc && cfgStb;
  assign cfgWrite  = cfgAccess && cfgWe;

  // One storage register per configuration word.
  for (genvar g = 0; g < NUM_CFG_REGS; g++) begin : g_cfgReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgRegs[g] <= '0;
      end else if (cfgWrite && (cfgAdr == CFG_AW'(g))) begin
        cfgRegs[g] <= cfgDatW;
      end
    end
  end

  // Read mux; unused indices return zero.
  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_CFG_REGS; i++) begin
      if (cfgAdr == CFG_AW'(i)) begin
        readVal = cfgRegs[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgAck  <= 1'b0;
      cfgDatR <= '0;
    end else begin
      cfgAck <= cfgAccess;
      if (cfgAccess && !cfgWe) begin
        cfgDatR <= readVal;
      end
    end
  end

  // Pending event counter: saturating increment, decrement on ack.
  always_comb begin
    pendNext = pendCnt;
    unique case ({eventPulse, strobe.msgDone})
      2'b10: if (pendCnt != CNT_MAX) pendNext = pendCnt + CNT_ONE;
      2'b01: if (pendCnt != CNT_ZERO) pendNext = pendCnt - CNT_ONE;
      default: pendNext = pendCnt;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else begin
      pendCnt <= pendNext;
    end
  end

  // Payload is frozen for the life of one message.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgAdr <= '0;
      msgDat <= '0;
    end else if (strobe.latchMsg) begin
      msgAdr <= cfgRegs[REG_TARGET];
      msgDat <= cfgRegs[REG_DATA];
    end
  end

  assign pendingAny  = (pendCnt != CNT_ZERO);
  assign targetValid = (cfgRegs[REG_TARGET] != '0);

endmodule

// File: rtl/irq_msg_control.sv
module irq_msg_control
  import irq_msg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pendingAny,
  input  logic       targetValid,
  input  logic       mStall,
  input  logic       mAck,
  output ctlStrobe_t strobe,
  output logic       mCyc,
  output logic       mStb,
  output logic       mWe
);

  msgState_t state;
  msgState_t stateNext;

  always_comb begin
    stateNext       = state;
    strobe.latchMsg = 1'b0;
    strobe.msgDone  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pendingAny && targetValid) begin
          strobe.latchMsg = 1'b1;
          stateNext       = ST_REQ;
        end
      end
      ST_REQ: begin
        if (!mStall) begin
          stateNext = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (mAck) begin
          strobe.msgDone = 1'b1;
          stateNext      = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  assign mCyc = (state == ST_REQ) || (state == ST_WAIT);
  assign mStb = (state == ST_REQ);
  assign mWe  = mCyc;

endmodule

// File: rtl/irq_msg_sender.sv
module irq_msg_sender
  import irq_msg_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int CNT_W  = 8,
  parameter int CFG_AW = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              eventPulse,
  input  logic              cfgCyc,
  input  logic              cfgStb,
  input  logic              cfgWe,
  input  logic [CFG_AW-1:0] cfgAdr,
  input  logic [BUS_W-1:0]  cfgDatW,
  output logic              cfgAck,
  output logic [BUS_W-1:0]  cfgDatR,
  output logic              mCyc,
  output logic              mStb,
  output logic              mWe,
  output logic [BUS_W-1:0]  mAdr,
  output logic [BUS_W-1:0]  mDat,
  input  logic              mStall,
  input  logic              mAck
);

  ctlStrobe_t ctlStrobe;
  logic       pendingAny;
  logic       targetValid;

  irq_msg_datapath #(
    .BUS_W (BUS_W),
    .CNT_W (CNT_W),
    .CFG_AW(CFG_AW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .eventPulse (eventPulse),
    .cfgCyc     (cfgCyc),
    .cfgStb     (cfgStb),
    .cfgWe      (cfgWe),
    .cfgAdr     (cfgAdr),
    .cfgDatW    (cfgDatW),
    .cfgAck     (cfgAck),
    .cfgDatR    (cfgDatR),
    .strobe     (ctlStrobe),
    .msgAdr     (mAdr),
    .msgDat     (mDat),
    .pendingAny (pendingAny),
    .targetValid(targetValid)
  );

  irq_msg_control u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .pendingAny (pendingAny),
    .targetValid(targetValid),
    .mStall     (mStall),
    .mAck       (mAck),
    .strobe     (ctlStrobe),
    .mCyc       (mCyc),
    .mStb       (mStb),
    .mWe        (mWe)
  );

endmodule

// File: rtl/irq_msg_sender_chk.sv
module irq_msg_sender_chk #(
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgCyc,
  input logic             cfgStb,
  input logic             cfgAck,
  input logic             mCyc,
  input logic             mStb,
  input logic             mWe,
  input logic [BUS_W-1:0] mAdr,
  input logic [BUS_W-1:0] mDat,
  input logic             mStall,
  input logic             mAck
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_idle_chk: assert (!mCyc && !mStb);
    end
  end

  // R2
  cfg_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgCyc && cfgStb |=> cfgAck);

  // R3
  we_with_stb_chk: assert property (@(posedge clk) disable iff (!rstN)
    mStb |-> mCyc && mWe);

  // R4
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mStb && mStall |=> mStb && $stable(mAdr) && $stable(mDat));

  // R5
  stb_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    mStb && !mStall |=> !mStb && mCyc);

  // R5
  cyc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    mCyc && !mStb && !mAck |=> mCyc && !mStb);

  // R5
  gap_after_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    mCyc && !mStb && mAck |=> !mCyc);

  // R6
  nonzero_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    mStb |-> mAdr != '0);

endmodule

bind irq_msg_sender irq_msg_sender_chk #(.BUS_W(BUS_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .cfgCyc(cfgCyc),
  .cfgStb(cfgStb),
  .cfgAck(cfgAck),
  .mCyc  (mCyc),
  .mStb  (mStb),
  .mWe   (mWe),
  .mAdr  (mAdr),
  .mDat  (mDat),
  .mStall(mStall),
  .mAck  (mAck)
);

// File: tb/irq_msg_sender_bench.sv
`timescale 1ns/1ps
module irq_msg_sender_bench;

  localparam int BUS_W  = 32;
  localparam int CNT_W  = 8;
  localparam int CFG_AW = 2;
  localparam int SAT    = (1 << CNT_W) - 1;
  localparam int LOGN   = 1024;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              evTask = 1'b0;
  logic              evAuto = 1'b0;
  logic              eventPulse;
  logic              cfgCyc = 1'b0, cfgStb = 1'b0, cfgWe = 1'b0;
  logic [CFG_AW-1:0] cfgAdr = '0;
  logic [BUS_W-1:0]  cfgDatW = '0;
  logic              cfgAck;
  logic [BUS_W-1:0]  cfgDatR;
  logic              mCyc, mStb, mWe;
  logic [BUS_W-1:0]  mAdr, mDat;
  logic              mStall = 1'b0;
  logic              mAck = 1'b0;

  int vecs = 0;
  int fails = 0;
  int cycles = 0;
  int stallCycles = 0;
  int ackDelay = 0;
  int autoLimit = 0;
  int autoUsed = 0;
  int writeCount = 0;
  logic [BUS_W-1:0] recAdr [LOGN];
  logic [BUS_W-1:0] recDat [LOGN];

  assign eventPulse = evTask | evAuto;

  always #4 clk = ~clk;

  irq_msg_sender #(.BUS_W(BUS_W), .CNT_W(CNT_W), .CFG_AW(CFG_AW)) u_irq_msg_sender (
    .clk(clk), .rstN(rstN), .eventPulse(eventPulse),
    .cfgCyc(cfgCyc), .cfgStb(cfgStb), .cfgWe(cfgWe), .cfgAdr(cfgAdr),
    .cfgDatW(cfgDatW), .cfgAck(cfgAck), .cfgDatR(cfgDatR),
    .mCyc(mCyc), .mStb(mStb), .mWe(mWe), .mAdr(mAdr), .mDat(mDat),
    .mStall(mStall), .mAck(mAck)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Receiver model, driven away from the active edge.
  int   stallSeen = 0;
  int   ackTimer = 0;
  bit   outstanding = 0;
  logic [BUS_W-1:0] holdAdr = '0, holdDat = '0;

  always @(negedge clk) begin
    evAuto = 1'b0;
    if (!rstN) begin
      mStall = 1'b0; mAck = 1'b0; stallSeen = 0; ackTimer = 0; outstanding = 0;
    end else begin
      if (mAck) outstanding = 0;
      mAck = 1'b0;
      if (ackTimer > 0) begin
        ackTimer--;
        if (ackTimer == 0) begin
          mAck = 1'b1;
          if (autoUsed < autoLimit) begin
            evAuto = 1'b1;  // R8: event coincides with ack
            autoUsed++;
          end
        end
      end
      if (outstanding) begin
        check(!mStb, "R5 strobe dropped after accept", mStb, 0);
        check(mCyc, "R5 cycle held until ack", mCyc, 1);
      end
      if (mCyc && mStb) begin
        check(mWe, "R3 write enable", mWe, 1);
        if (stallSeen == 0) begin
          holdAdr = mAdr; holdDat = mDat;
        end else begin
          check(mAdr == holdAdr && mDat == holdDat, "R4 payload stable in stall",
                {mAdr, mDat}, {holdAdr, holdDat});
        end
        if (stallSeen < stallCycles) begin
          mStall = 1'b1;
          stallSeen++;
        end else begin
          mStall = 1'b0;
          if (writeCount < LOGN) begin
            recAdr[writeCount] = mAdr;
            recDat[writeCount] = mDat;
          end
          writeCount++;
          stallSeen = 0;
          ackTimer = ackDelay + 1;
          outstanding = 1;
        end
      end else begin
        mStall = 1'b0;
      end
    end
  end

  task automatic cfgWrite(input logic [CFG_AW-1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk);
    cfgCyc = 1; cfgStb = 1; cfgWe = 1; cfgAdr = a; cfgDatW = d;
    @(negedge clk);
    cfgCyc = 0; cfgStb = 0; cfgWe = 0;
    check(cfgAck, "R2 write ack", cfgAck, 1);
  endtask

  task automatic cfgRead(input logic [CFG_AW-1:0] a, output logic [BUS_W-1:0] d);
    @(negedge clk);
    cfgCyc = 1; cfgStb = 1; cfgWe = 0; cfgAdr = a;
    @(negedge clk);
    cfgCyc = 0; cfgStb = 0;
    check(cfgAck, "R2 read ack", cfgAck, 1);
    d = cfgDatR;
  endtask

  task automatic pulseEvents(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evTask = 1'b1;
    end
    @(negedge clk);
    evTask = 1'b0;
  endtask

  task automatic waitDrain(input int expTotal, input string req);
    for (int i = 0; i < 6000 && writeCount < expTotal; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    check(writeCount == expTotal, req, writeCount, expTotal);
  endtask

  task automatic checkPayload(input int first, input int last,
                              input logic [BUS_W-1:0] a, input logic [BUS_W-1:0] d);
    for (int i = first; i < last && i < LOGN; i++) begin
      check(recAdr[i] == a && recDat[i] == d, "R3 message payload",
            {recAdr[i], recDat[i]}, {a, d});
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected finish", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [BUS_W-1:0] rd;
    int base;
    logic [BUS_W-1:0] tgt;
    logic [BUS_W-1:0] dat;

    repeat (3) @(negedge clk);
    check(!mCyc && !mStb, "R1 master idle in reset", {mCyc, mStb}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!mCyc && !mStb, "R1 master idle after reset", {mCyc, mStb}, 0);
    cfgRead(0, rd); check(rd == 0, "R1 target cleared", rd, 0);
    cfgRead(1, rd); check(rd == 0, "R1 data cleared", rd, 0);

    // R2: readback and reserved window
    cfgWrite(1, 32'hA5A5_0001);
    cfgWrite(3, 32'hFFFF_FFFF);
    cfgRead(1, rd); check(rd == 32'hA5A5_0001, "R2 data readback", rd, 32'hA5A5_0001);
    cfgRead(3, rd); check(rd == 0, "R2 reserved reads zero", rd, 0);
    cfgRead(0, rd); check(rd == 0, "R2 reserved write ignored", rd, 0);

    // R6: events held while target is zero
    pulseEvents(5);
    repeat (20) @(negedge clk);
    check(writeCount == 0, "R6 no write with zero target", writeCount, 0);
    cfgWrite(0, 32'h1000_0040);
    cfgRead(0, rd); check(rd == 32'h1000_0040, "R2 target readback", rd, 32'h1000_0040);
    waitDrain(5, "R6 drain after target set");
    checkPayload(0, 5, 32'h1000_0040, 32'hA5A5_0001);

    // R3, R4, R5: sweep stall and ack latency
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 4; a++) begin
        stallCycles = s; ackDelay = a;
        tgt = 32'h2000_0000 + 32'(s * 16 + a * 4);
        dat = 32'hD000_0000 + 32'(s * 4 + a);
        cfgWrite(0, tgt);
        cfgWrite(1, dat);
        base = writeCount;
        pulseEvents(3);
        waitDrain(base + 3, "R3 one write per event");
        checkPayload(base, base + 3, tgt, dat);
      end
    end

    // R7: saturation
    stallCycles = 0; ackDelay = 0;
    cfgWrite(0, 0);
    base = writeCount;
    pulseEvents(SAT + 45);
    repeat (20) @(negedge clk);
    check(writeCount == base, "R6 counted not sent", writeCount, base);
    cfgWrite(1, 32'h0000_7777);
    cfgWrite(0, 32'h3000_0100);
    waitDrain(base + SAT, "R7 saturated count drained");
    checkPayload(base, base + SAT, 32'h3000_0100, 32'h0000_7777);

    // R8: event on every ack cycle
    ackDelay = 1; stallCycles = 1;
    base = writeCount;
    autoLimit = autoUsed + 20;
    pulseEvents(1);
    waitDrain(base + 21, "R8 event with ack kept");

    // R9: data write during an in-flight message
    autoLimit = autoUsed;
    stallCycles = 6; ackDelay = 1;
    cfgWrite(1, 32'h0000_00A1);
    base = writeCount;
    pulseEvents(2);
    cfgWrite(1, 32'h0000_00B2);
    waitDrain(base + 2, "R9 two messages");
    check(recDat[base] == 32'h0000_00A1, "R9 in-flight message kept old data",
          recDat[base], 32'h0000_00A1);
    check(recDat[base + 1] == 32'h0000_00B2, "R9 next message uses new data",
          recDat[base + 1], 32'h0000_00B2);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

endmodule